// File: doc/BRIEF.md
# Root Port Power-Management Event Logger

This block sits behind a PCI Express root port. It accepts power-management-event messages, each tagged with a 16-bit requester ID. The first message goes into a status slot that software can see. A second message waits in a hidden slot. When software acknowledges the visible entry by clearing its flag, the waiting entry moves up into the visible slot by itself. Messages that arrive while both slots are occupied are discarded.

Each time an entry becomes visible, whether from a new message or from a promotion, the block raises an event. The control enables steer that event. If the interrupt enable is set, the event becomes an interrupt pulse. If it is clear, the event becomes a request to the power-management controller for a general-purpose event. Two further enables act independently of the interrupt choice and of each other: one sets a sticky SCI status flag, and the other sets a sticky SMI status flag and pulses an SMI request. Raising the interrupt enable while an entry is already visible produces a late interrupt, so a message that came in before interrupts were re-enabled after resume is not lost.

Software reaches three 32-bit registers through a simple write port and a combinational read port.

Top module: `pme_logger`

## Requirements
- R1: After synchronous reset, every register reads zero: control (address 0), log (address 1) and event status (address 2). The irq, gpe and smi_req outputs are low. The control register reads back the last word written to it; its bit 0 is the interrupt enable, bit 1 the SCI enable and bit 2 the SMI enable.
- R2: A message that arrives while the visible flag is clear sets the flag, which is log bit 16. It also puts its requester ID into log bits 15:0. Both are visible in the cycle after the message.
- R3: A message that arrives while the visible flag is set and the waiting flag (log bit 17) is clear is held in the hidden slot. It sets the waiting flag and leaves log bits 16:0 unchanged. A message that arrives while both flags are set is discarded.
- R4: Writing 1 to log bit 16 while the waiting flag is set keeps the visible flag set, clears the waiting flag and shows the hidden ID in bits 15:0. A message that arrives in that same cycle takes the freed hidden slot.
- R5: Writing 1 to log bit 16 with no entry waiting clears the visible flag and leaves the ID field as it was. Writing 0 to log bit 16 changes nothing.
- R6: An event is a message that becomes visible or a promotion. With the interrupt enable set, an event produces a one-cycle irq pulse in the cycle after the event.
- R7: With the interrupt enable clear, an event produces a one-cycle gpe pulse and no irq.
- R8: A control write that raises the interrupt enable from 0 to 1 produces a one-cycle irq pulse if the visible flag is set. It produces no pulse if the flag is clear or the enable was already 1.
- R9: With the SCI enable set, an event sets event-status bit 31 and the sci_sts output. The bit stays set until software writes 1 to it. An event in the same cycle as that clear leaves the bit set.
- R10: With the SMI enable set, an event sets event-status bit 0 (sticky, write-1-to-clear) and pulses smi_req for one cycle. This happens whatever the other enables are, and in the same cycle as any irq or gpe pulse.
- R11: A message that goes into the hidden slot, or that is discarded, raises no event: no irq, gpe, smi_req, or status bit change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Power-management message strobe, one cycle per message |
| msg_rid | input | 16 | Requester ID carried by the message |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 log, 2 event status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt pulse |
| gpe | output | 1 | General-purpose-event request pulse |
| sci_sts | output | 1 | Sticky SCI status flag |
| smi_req | output | 1 | SMI request pulse |

## Verification
The log is driven with four patterns:
- A lone message shows where a fresh entry lands.
- A second message shows that it is held hidden with no event.
- A third message shows that it is dropped.
- A status clear that coincides with a new message shows that promotion and hidden capture happen together.

Routing is tried with each enable alone and with combinations. Comparing the irq, gpe, smi_req and status bits across these runs separates the exclusive interrupt/GPE choice from the two independent sticky paths. Rewriting the interrupt enable is done with the visible flag set, with it clear, and with the enable already at 1, which isolates the late-interrupt edge. A sticky clear in the same cycle as an event checks that set wins.

// File: rtl/pme_log_pkg.sv
package pme_log_pkg;

    localparam int RID_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // control word bit positions
    localparam int CTL_INT_BIT = 0;
    localparam int CTL_SCI_BIT = 1;
    localparam int CTL_SMI_BIT = 2;

    // log register bit positions
    localparam int LOG_VIS_BIT  = RID_W;
    localparam int LOG_WAIT_BIT = RID_W + 1;

    // event status register bit positions
    localparam int EVS_SCI_BIT = 31;
    localparam int EVS_SMI_BIT = 0;

    typedef logic [RID_W-1:0]  rid_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOG   = 2'd1,
        SEL_EVSTS = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic smi_en;
        logic sci_en;
        logic int_en;
    } route_en_t;

    typedef struct packed {
        logic ack_log;
        logic ack_sci;
        logic ack_smi;
        logic int_rise;
    } sw_cmd_t;

    typedef struct packed {
        logic vis;
        logic wait_full;
        rid_t rid;
    } log_view_t;

    function automatic word_t log_word(log_view_t v);
        word_t w;
        w = '0;
        w[RID_W-1:0]   = v.rid;
        w[LOG_VIS_BIT]  = v.vis;
        w[LOG_WAIT_BIT] = v.wait_full;
        return w;
    endfunction

    function automatic word_t evsts_word(logic sci, logic smi);
        word_t w;
        w = '0;
        w[EVS_SCI_BIT] = sci;
        w[EVS_SMI_BIT] = smi;
        return w;
    endfunction

endpackage

// File: rtl/pme_log_regs.sv
module pme_log_regs
    import pme_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  log_view_t         view,
    input  logic              sci_flag,
    input  logic              smi_flag,
    output route_en_t         en,
    output sw_cmd_t           cmd,
    output word_t             rd_data
);

    word_t ctrl_q;
    logic  hit_ctrl, hit_log, hit_evs;

    assign hit_ctrl = wr_en && (wr_addr == SEL_CTRL);
    assign hit_log  = wr_en && (wr_addr == SEL_LOG);
    assign hit_evs  = wr_en && (wr_addr == SEL_EVSTS);

    always_ff @(posedge clk) begin
        if (rst)           ctrl_q <= '0;
        else if (hit_ctrl) ctrl_q <= wr_data;
    end

    assign en.int_en = ctrl_q[CTL_INT_BIT];
    assign en.sci_en = ctrl_q[CTL_SCI_BIT];
    assign en.smi_en = ctrl_q[CTL_SMI_BIT];

    always_comb begin
        cmd.ack_log  = hit_log && wr_data[LOG_VIS_BIT];
        cmd.ack_sci  = hit_evs && wr_data[EVS_SCI_BIT];
        cmd.ack_smi  = hit_evs && wr_data[EVS_SMI_BIT];
        cmd.int_rise = hit_ctrl && wr_data[CTL_INT_BIT] && !en.int_en && view.vis;
    end

    always_comb begin
        case (rd_addr)
            SEL_CTRL:  rd_data = ctrl_q;
            SEL_LOG:   rd_data = log_word(view);
            SEL_EVSTS: rd_data = evsts_word(sci_flag, smi_flag);
            default:   rd_data = '0;
        endcase
    end

    // R8: the late-interrupt strobe only fires on a genuine rising edge
    p_rise_only_from_low_r8: assert property (@(posedge clk) disable iff (rst)
        cmd.int_rise |=> en.int_en);

endmodule

// File: rtl/pme_log_slots.sv
module pme_log_slots
    import pme_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      msg_valid,
    input  rid_t      msg_rid,
    input  logic      ack,
    output log_view_t view,
    output logic      evt
);

    logic vis_q, wait_q;
    rid_t rid_q, hid_q;
    logic vis_n, wait_n;
    rid_t rid_n, hid_n;
    logic promote, vis_after_ack;

    always_comb begin
        promote       = ack && wait_q;
        vis_after_ack = vis_q && !ack;
        vis_n  = vis_q;
        wait_n = wait_q;
        rid_n  = rid_q;
        hid_n  = hid_q;
        evt    = 1'b0;
        if (promote) begin
            vis_n  = 1'b1;
            wait_n = 1'b0;
            rid_n  = hid_q;
            evt    = 1'b1;
        end else if (ack) begin
            vis_n = 1'b0;
        end
        if (msg_valid) begin
            if (!promote && !vis_after_ack) begin
                vis_n = 1'b1;
                rid_n = msg_rid;
                evt   = 1'b1;
            end else if (promote || !wait_q) begin
                hid_n  = msg_rid;
                wait_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q  <= 1'b0;
            wait_q <= 1'b0;
            rid_q  <= '0;
            hid_q  <= '0;
        end else begin
            vis_q  <= vis_n;
            wait_q <= wait_n;
            rid_q  <= rid_n;
            hid_q  <= hid_n;
        end
    end

    assign view.vis       = vis_q;
    assign view.wait_full = wait_q;
    assign view.rid       = rid_q;

    // R3: a waiting entry never exists without a visible one
    p_wait_needs_vis_r3: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> vis_q);

    // R3: a message meeting a full log leaves the visible entry alone
    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && vis_q && wait_q && !ack) |=> (rid_q == $past(rid_q)) && wait_q);

    // R4: acknowledging with an entry waiting promotes it
    p_promote_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && wait_q && !msg_valid) |=> vis_q && !wait_q && (rid_q == $past(hid_q)));

endmodule

// File: rtl/pme_log_route.sv
module pme_log_route
    import pme_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  route_en_t en,
    input  sw_cmd_t   cmd,
    output logic      irq,
    output logic      gpe,
    output logic      smi_req,
    output logic      sci_flag,
    output logic      smi_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            gpe      <= 1'b0;
            smi_req  <= 1'b0;
            sci_flag <= 1'b0;
            smi_flag <= 1'b0;
        end else begin
            irq      <= (evt && en.int_en) || cmd.int_rise;
            gpe      <= evt && !en.int_en;
            smi_req  <= evt && en.smi_en;
            sci_flag <= (sci_flag && !cmd.ack_sci) || (evt && en.sci_en);
            smi_flag <= (smi_flag && !cmd.ack_smi) || (evt && en.smi_en);
        end
    end

    p_irq_on_event_r6: assert property (@(posedge clk) disable iff (rst)
        (evt && en.int_en) |=> irq && !gpe);

    p_gpe_on_event_r7: assert property (@(posedge clk) disable iff (rst)
        (evt && !en.int_en && !cmd.int_rise) |=> gpe && !irq);

    p_sci_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (evt && en.sci_en) |=> sci_flag);

    p_smi_both_r10: assert property (@(posedge clk) disable iff (rst)
        (evt && en.smi_en) |=> smi_req && smi_flag);

    p_quiet_without_event_r11: assert property (@(posedge clk) disable iff (rst)
        (!evt && !cmd.int_rise) |=> !irq && !gpe && !smi_req);

endmodule

// File: rtl/pme_logger.sv
module pme_logger
    import pme_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [RID_W-1:0]  msg_rid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              gpe,
    output logic              sci_sts,
    output logic              smi_req
);

    log_view_t view;
    route_en_t en;
    sw_cmd_t   cmd;
    logic      evt;
    logic      sci_flag, smi_flag;

    pme_log_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .view     (view),
        .sci_flag (sci_flag),
        .smi_flag (smi_flag),
        .en       (en),
        .cmd      (cmd),
        .rd_data  (rd_data)
    );

    pme_log_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .msg_valid (msg_valid),
        .msg_rid   (msg_rid),
        .ack       (cmd.ack_log),
        .view      (view),
        .evt       (evt)
    );

    pme_log_route u_route (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .en       (en),
        .cmd      (cmd),
        .irq      (irq),
        .gpe      (gpe),
        .smi_req  (smi_req),
        .sci_flag (sci_flag),
        .smi_flag (smi_flag)
    );

    assign sci_sts = sci_flag;

    // R5: a lone acknowledge empties the visible slot
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack_log && !view.wait_full && !msg_valid) |=> !view.vis);

endmodule

// File: tb/pme_logger_test.sv
`timescale 1ns/1ps
module pme_logger_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic [15:0] msg_rid = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, gpe, sci_sts, smi_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pme_logger uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_rid(msg_rid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .gpe(gpe), .sci_sts(sci_sts), .smi_req(smi_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.3;
        check(tag, rd_data, exp);
    endtask

    task automatic pulses(input string tag, input logic e_irq, input logic e_gpe, input logic e_smi);
        check({tag, " irq"}, {31'd0, irq}, {31'd0, e_irq});
        check({tag, " gpe"}, {31'd0, gpe}, {31'd0, e_gpe});
        check({tag, " smi_req"}, {31'd0, smi_req}, {31'd0, e_smi});
    endtask

    task automatic send(input logic [15:0] id);
        msg_valid = 1'b1;
        msg_rid   = id;
        tick();
        msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        read_chk("R1 ctrl after reset", 2'd0, 32'h0);
        read_chk("R1 log after reset", 2'd1, 32'h0);
        read_chk("R1 evsts after reset", 2'd2, 32'h0);
        pulses("R1 reset", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_first_msg();
        send(16'h1234);
        pulses("R7 first msg", 1'b0, 1'b1, 1'b0);
        read_chk("R2 first msg log", 2'd1, 32'h0001_1234);
        tick();
        pulses("R7 gpe single cycle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hidden_and_drop();
        send(16'hBEEF);
        pulses("R11 hidden msg quiet", 1'b0, 1'b0, 1'b0);
        read_chk("R3 hidden held", 2'd1, 32'h0003_1234);
        send(16'h5555);
        pulses("R11 dropped msg quiet", 1'b0, 1'b0, 1'b0);
        read_chk("R3 dropped msg", 2'd1, 32'h0003_1234);
        wr(2'd1, 32'h0000_0000);
        read_chk("R5 write zero no effect", 2'd1, 32'h0003_1234);
        wr(2'd1, 32'h0001_0000);
        pulses("R4 promotion event", 1'b0, 1'b1, 1'b0);
        read_chk("R4 promoted", 2'd1, 32'h0001_BEEF);
        wr(2'd1, 32'h0001_0000);
        read_chk("R5 plain clear", 2'd1, 32'h0000_BEEF);
        pulses("R5 plain clear quiet", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_clear_with_msg();
        send(16'h0A0A);
        send(16'h0B0B);
        msg_valid = 1'b1; msg_rid = 16'h0C0C;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0001_0000;
        tick();
        msg_valid = 1'b0; wr_en = 1'b0;
        read_chk("R4 promote plus capture", 2'd1, 32'h0003_0B0B);
        wr(2'd1, 32'h0001_0000);
        read_chk("R4 second promotion", 2'd1, 32'h0001_0C0C);
        wr(2'd1, 32'h0001_0000);
        read_chk("R5 log emptied", 2'd1, 32'h0000_0C0C);
    endtask

    task automatic t_irq();
        wr(2'd0, 32'h0000_0001);
        pulses("R8 rise with empty log", 1'b0, 1'b0, 1'b0);
        read_chk("R1 ctrl readback", 2'd0, 32'h0000_0001);
        send(16'h0101);
        pulses("R6 irq on event", 1'b1, 1'b0, 1'b0);
        tick();
        pulses("R6 irq single cycle", 1'b0, 1'b0, 1'b0);
        wr(2'd1, 32'h0001_0000);
    endtask

    task automatic t_late_irq();
        wr(2'd0, 32'h0000_0000);
        send(16'h0202);
        pulses("R7 gpe with int off", 1'b0, 1'b1, 1'b0);
        wr(2'd0, 32'h0000_0001);
        pulses("R8 late irq", 1'b1, 1'b0, 1'b0);
        wr(2'd0, 32'h0000_0001);
        pulses("R8 no irq when already on", 1'b0, 1'b0, 1'b0);
        wr(2'd1, 32'h0001_0000);
        wr(2'd0, 32'h0000_0000);
    endtask

    task automatic t_sci();
        wr(2'd0, 32'h0000_0002);
        send(16'h0303);
        pulses("R9 sci path", 1'b0, 1'b1, 1'b0);
        read_chk("R9 sci bit", 2'd2, 32'h8000_0000);
        check("R9 sci_sts port", {31'd0, sci_sts}, 32'd1);
        wr(2'd1, 32'h0001_0000);
        tick();
        check("R9 sci sticky", {31'd0, sci_sts}, 32'd1);
        wr(2'd2, 32'h8000_0000);
        read_chk("R9 sci cleared", 2'd2, 32'h0);
        msg_valid = 1'b1; msg_rid = 16'h0404;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h8000_0000;
        tick();
        msg_valid = 1'b0; wr_en = 1'b0;
        read_chk("R9 set beats clear", 2'd2, 32'h8000_0000);
        wr(2'd1, 32'h0001_0000);
        wr(2'd2, 32'h8000_0000);
    endtask

    task automatic t_smi();
        wr(2'd0, 32'h0000_0005);
        pulses("R8 no rise irq on empty log", 1'b0, 1'b0, 1'b0);
        send(16'h0505);
        pulses("R10 smi with irq", 1'b1, 1'b0, 1'b1);
        read_chk("R10 smi bit", 2'd2, 32'h0000_0001);
        tick();
        pulses("R10 smi single cycle", 1'b0, 1'b0, 1'b0);
        read_chk("R10 smi sticky", 2'd2, 32'h0000_0001);
        wr(2'd2, 32'h0000_0001);
        read_chk("R10 smi cleared", 2'd2, 32'h0);
        wr(2'd1, 32'h0001_0000);
        wr(2'd0, 32'h0000_0006);
        send(16'h0606);
        pulses("R10 smi with gpe", 1'b0, 1'b1, 1'b1);
        read_chk("R10 sci and smi", 2'd2, 32'h8000_0001);
        check("R10 sci port", {31'd0, sci_sts}, 32'd1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_first_msg();
        t_hidden_and_drop();
        t_clear_with_msg();
        t_irq();
        t_late_irq();
        t_sci();
        t_smi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule